// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Servicer

This block sits between a set of interrupt pins and the message fabric that carries interrupts to processors. It keeps a pending-request bit for every pin and decides, each cycle, whether a pin may send an interrupt message. The message is built from that pin's steering entry: vector, destination, destination mode, delivery mode and trigger kind. It leaves the block through a valid/ready handshake. Edge pins latch a rising edge until it is delivered, and a further edge that arrives meanwhile is folded into the one already pending. Level pins follow the wire. After an accepted delivery, a level pin is blocked by an in-service bit until an end-of-interrupt broadcast with the same vector releases it.

When an end-of-interrupt releases a level pin that is still asserted, the pin fires again at once. A per-pin counter tracks these back-to-back repeats. When the counter reaches `STORM_LIMIT`, the pin is held back and a single shared timer of `DEFER_CYCLES` clock cycles starts. When the timer expires, every held pin is released and re-enters arbitration. The steering entries are plain inputs. Register access and the receiving interrupt controllers are outside this block.

Top module: `irq_pin_servicer`

## Requirements
- R1: After reset, all request bits, in-service bits and coalesce flags are 0, and `msgValid` is 0.
- R2: A rising edge on any pin sets its request bit in the following cycle. A falling edge on a level pin (`cfgLevelTrig`=1) clears the bit, and the pin then delivers nothing. An edge pin keeps its bit after its wire falls, until the bit is delivered.
- R3: A rising edge on an edge pin whose request bit is already set produces no extra message. It raises `coalesced[p]` for exactly one cycle, one cycle after the edge.
- R4: A level pin whose in-service bit is set sends no message, and its request bit stays set while the wire is high.
- R5: A pin with `cfgMask[p]`=1 never sends a message and keeps its request bit. Clearing the mask lets the pending request go out.
- R6: A pin that is able to send causes `msgValid` one cycle after it becomes able. The message carries that pin's entry fields and its index on `msgPin`. The lowest index goes first. While `msgReady` is low, every message output holds steady.
- R7: On an accepted message (`msgValid` and `msgReady` both high), an edge pin's request bit clears and a level pin's in-service bit sets.
- R8: An end-of-interrupt with vector V clears the in-service bit of every level entry whose vector equals V. With `directedEoi`=1 it clears nothing. Entries with a different vector are untouched.
- R9: When such a clear hits a pin that is unmasked and has its request bit set, that pin's repeat counter increments and the pin is offered again with `msgValid` one cycle after the clear. Otherwise the counter returns to 0.
- R10: The repeat that would bring the counter to `STORM_LIMIT` resets the counter to 0 and holds the pin back instead. Its message then appears `DEFER_CYCLES`+1 cycles after the end-of-interrupt edge.
- R11: Reset cancels a pending deferral. After reset a newly asserted pin is offered without waiting for the old timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | NUM_PINS | Interrupt wires, one per pin |
| cfgVector | input | NUM_PINS*VEC_W | Vector of each entry, pin p at bits [p*VEC_W +: VEC_W] |
| cfgDest | input | NUM_PINS*DEST_W | Destination of each entry |
| cfgDestMode | input | NUM_PINS | Destination mode bit of each entry |
| cfgDelivMode | input | NUM_PINS*MODE_W | Delivery mode of each entry |
| cfgLevelTrig | input | NUM_PINS | 1 = level-triggered, 0 = edge-triggered |
| cfgMask | input | NUM_PINS | 1 = entry masked |
| eoiValid | input | 1 | End-of-interrupt broadcast strobe |
| eoiVector | input | VEC_W | Vector carried by the broadcast |
| directedEoi | input | 1 | 1 = broadcast must not clear in-service bits |
| msgReady | input | 1 | Downstream accepts the message |
| msgValid | output | 1 | Message offered |
| msgVector | output | VEC_W | Message vector |
| msgDest | output | DEST_W | Message destination |
| msgDestMode | output | 1 | Message destination mode |
| msgDelivMode | output | MODE_W | Message delivery mode |
| msgLevelTrig | output | 1 | Message trigger kind |
| msgPin | output | 6 | Index of the pin that sent the message |
| irr | output | NUM_PINS | Request bit of each pin |
| remoteIrr | output | NUM_PINS | In-service bit of each pin |
| coalesced | output | NUM_PINS | One-cycle flag: an edge was folded into a pending request |

## Verification
The bench builds the block with four pins, `STORM_LIMIT`=3 and `DEFER_CYCLES`=20. These small values put the throttling path within a few dozen cycles. The storm threshold, the counter restart after a non-repeating end-of-interrupt, and the exact deferral latency can all be measured cycle by cycle. With four pins, every pin can be swept through edge delivery and coalescing. The same small count allows a full simultaneous-request pass that checks lowest-index ordering, and a shared-vector broadcast that hits two level pins and one edge pin together.

// File: rtl/pinsvc_pkg.sv
package pinsvc_pkg;
  // Pin index width carried between control and datapath (up to 64 pins).
  localparam int MaxPinW = 6;

  typedef struct packed {
    logic               load;  // capture a new message this cycle
    logic [MaxPinW-1:0] pin;   // pin whose entry is captured
  } msgCtl_t;
endpackage

// File: rtl/pinsvc_ctrl.sv
module pinsvc_ctrl
  import pinsvc_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int VEC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 1250000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_PINS-1:0]       pinLevel,
  input  logic [NUM_PINS-1:0]       cfgLevelTrig,
  input  logic [NUM_PINS-1:0]       cfgMask,
  input  logic [NUM_PINS*VEC_W-1:0] cfgVector,
  input  logic                      eoiValid,
  input  logic [VEC_W-1:0]          eoiVector,
  input  logic                      directedEoi,
  input  logic                      msgValid,
  input  logic                      msgReady,
  input  logic                      msgLevelTrig,
  input  logic [MaxPinW-1:0]        msgPin,
  output msgCtl_t                   ctl,
  output logic [NUM_PINS-1:0]       irr,
  output logic [NUM_PINS-1:0]       remoteIrr,
  output logic [NUM_PINS-1:0]       coalesced
);
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);
  localparam int TMR_W = $clog2(DEFER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CntTop = CNT_W'(STORM_LIMIT - 1);
  localparam logic [TMR_W-1:0] TmrTop = TMR_W'(DEFER_CYCLES - 1);

  logic [NUM_PINS-1:0] prevLevel, rise, fall, hold, newHold, eligible;
  logic                accept, timerActive, timerFire;
  logic [TMR_W-1:0]    timerCnt;

  assign rise      = pinLevel & ~prevLevel;
  assign fall      = ~pinLevel & prevLevel;
  assign accept    = msgValid && msgReady;
  assign timerFire = timerActive && (timerCnt == TmrTop);
  assign eligible  = irr & ~cfgMask & ~hold & (~cfgLevelTrig | ~remoteIrr);

  // Per-pin request, in-service, storm counter and hold state.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CNT_W-1:0] eoiCnt;
    logic             acceptHit, eoiHit, eoiRepeat;

    assign acceptHit  = accept && (msgPin == MaxPinW'(p));
    assign eoiHit     = eoiValid && !directedEoi && cfgLevelTrig[p] &&
                        (cfgVector[p*VEC_W +: VEC_W] == eoiVector);
    assign eoiRepeat  = eoiHit && irr[p] && !cfgMask[p];
    assign newHold[p] = eoiRepeat && (eoiCnt == CntTop);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevLevel[p] <= 1'b0;
        coalesced[p] <= 1'b0;
        irr[p]       <= 1'b0;
        remoteIrr[p] <= 1'b0;
        hold[p]      <= 1'b0;
        eoiCnt       <= '0;
      end else begin
        prevLevel[p] <= pinLevel[p];
        coalesced[p] <= rise[p] && !cfgLevelTrig[p] && irr[p];
        if (acceptHit && !msgLevelTrig)      irr[p] <= 1'b0;
        else if (fall[p] && cfgLevelTrig[p]) irr[p] <= 1'b0;
        else if (rise[p])                    irr[p] <= 1'b1;
        if (acceptHit && msgLevelTrig) remoteIrr[p] <= 1'b1;
        else if (eoiHit)               remoteIrr[p] <= 1'b0;
        if (eoiRepeat)   eoiCnt <= newHold[p] ? '0 : eoiCnt + 1'b1;
        else if (eoiHit) eoiCnt <= '0;
        hold[p] <= newHold[p] | (hold[p] & ~timerFire);
      end
    end

    a_r2_level_fall_clears: assert property (@(posedge clk) disable iff (!rstN)
      (cfgLevelTrig[p] && $fell(pinLevel[p]) && !(acceptHit && !msgLevelTrig)) |=> !irr[p]);
    a_r7_edge_accept_clears: assert property (@(posedge clk) disable iff (!rstN)
      (accept && !msgLevelTrig && msgPin == MaxPinW'(p)) |=> !irr[p]);
    a_r7_level_accept_sets: assert property (@(posedge clk) disable iff (!rstN)
      (accept && msgLevelTrig && msgPin == MaxPinW'(p)) |=> remoteIrr[p]);
    a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
      eoiCnt < CNT_W'(STORM_LIMIT));
  end

  // Single shared deferral timer.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerActive <= 1'b0;
      timerCnt    <= '0;
    end else if ((|newHold) && (!timerActive || timerFire)) begin
      timerActive <= 1'b1;
      timerCnt    <= '0;
    end else if (timerFire) begin
      timerActive <= 1'b0;
    end else if (timerActive) begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  // Lowest eligible index wins; only when no message is outstanding.
  always_comb begin
    ctl.pin  = '0;
    ctl.load = !msgValid && (|eligible);
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (eligible[p]) ctl.pin = MaxPinW'(p);
    end
  end

  a_r10_hold_needs_timer: assert property (@(posedge clk) disable iff (!rstN)
    (|hold) |-> timerActive);
endmodule

// File: rtl/pinsvc_msg.sv
module pinsvc_msg
  import pinsvc_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int DEST_W   = 8,
  parameter int MODE_W   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  msgCtl_t                    ctl,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic [NUM_PINS-1:0]        cfgDestMode,
  input  logic [NUM_PINS*MODE_W-1:0] cfgDelivMode,
  input  logic [NUM_PINS-1:0]        cfgLevelTrig,
  input  logic                       msgReady,
  output logic                       msgValid,
  output logic [VEC_W-1:0]           msgVector,
  output logic [DEST_W-1:0]          msgDest,
  output logic                       msgDestMode,
  output logic [MODE_W-1:0]          msgDelivMode,
  output logic                       msgLevelTrig,
  output logic [MaxPinW-1:0]         msgPin
);
  logic [VEC_W-1:0]  selVector;
  logic [DEST_W-1:0] selDest;
  logic [MODE_W-1:0] selDeliv;
  logic              selDestMode, selLevel;

  always_comb begin
    selVector   = '0;
    selDest     = '0;
    selDeliv    = '0;
    selDestMode = 1'b0;
    selLevel    = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (ctl.pin == MaxPinW'(p)) begin
        selVector   = cfgVector[p*VEC_W +: VEC_W];
        selDest     = cfgDest[p*DEST_W +: DEST_W];
        selDeliv    = cfgDelivMode[p*MODE_W +: MODE_W];
        selDestMode = cfgDestMode[p];
        selLevel    = cfgLevelTrig[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid     <= 1'b0;
      msgVector    <= '0;
      msgDest      <= '0;
      msgDestMode  <= 1'b0;
      msgDelivMode <= '0;
      msgLevelTrig <= 1'b0;
      msgPin       <= '0;
    end else if (ctl.load) begin
      msgValid     <= 1'b1;
      msgVector    <= selVector;
      msgDest      <= selDest;
      msgDestMode  <= selDestMode;
      msgDelivMode <= selDeliv;
      msgLevelTrig <= selLevel;
      msgPin       <= ctl.pin;
    end else if (msgValid && msgReady) begin
      msgValid <= 1'b0;
    end
  end

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgVector) && $stable(msgDest) &&
      $stable(msgDestMode) && $stable(msgDelivMode) && $stable(msgPin)));
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !msgValid);
endmodule

// File: rtl/irq_pin_servicer.sv
module irq_pin_servicer
  import pinsvc_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int MODE_W       = 3,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 1250000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        pinLevel,
  input  logic [NUM_PINS*VEC_W-1:0]  cfgVector,
  input  logic [NUM_PINS*DEST_W-1:0] cfgDest,
  input  logic [NUM_PINS-1:0]        cfgDestMode,
  input  logic [NUM_PINS*MODE_W-1:0] cfgDelivMode,
  input  logic [NUM_PINS-1:0]        cfgLevelTrig,
  input  logic [NUM_PINS-1:0]        cfgMask,
  input  logic                       eoiValid,
  input  logic [VEC_W-1:0]           eoiVector,
  input  logic                       directedEoi,
  input  logic                       msgReady,
  output logic                       msgValid,
  output logic [VEC_W-1:0]           msgVector,
  output logic [DEST_W-1:0]          msgDest,
  output logic                       msgDestMode,
  output logic [MODE_W-1:0]          msgDelivMode,
  output logic                       msgLevelTrig,
  output logic [MaxPinW-1:0]         msgPin,
  output logic [NUM_PINS-1:0]        irr,
  output logic [NUM_PINS-1:0]        remoteIrr,
  output logic [NUM_PINS-1:0]        coalesced
);
  msgCtl_t ctl;

  pinsvc_ctrl #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W),
    .STORM_LIMIT(STORM_LIMIT), .DEFER_CYCLES(DEFER_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .cfgLevelTrig(cfgLevelTrig),
    .cfgMask(cfgMask), .cfgVector(cfgVector), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .directedEoi(directedEoi), .msgValid(msgValid),
    .msgReady(msgReady), .msgLevelTrig(msgLevelTrig), .msgPin(msgPin),
    .ctl(ctl), .irr(irr), .remoteIrr(remoteIrr), .coalesced(coalesced)
  );

  pinsvc_msg #(
    .NUM_PINS(NUM_PINS), .VEC_W(VEC_W), .DEST_W(DEST_W), .MODE_W(MODE_W)
  ) u_msg (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgVector(cfgVector), .cfgDest(cfgDest),
    .cfgDestMode(cfgDestMode), .cfgDelivMode(cfgDelivMode),
    .cfgLevelTrig(cfgLevelTrig), .msgReady(msgReady), .msgValid(msgValid),
    .msgVector(msgVector), .msgDest(msgDest), .msgDestMode(msgDestMode),
    .msgDelivMode(msgDelivMode), .msgLevelTrig(msgLevelTrig), .msgPin(msgPin)
  );
endmodule

// File: tb/sim_irq_pin_servicer.sv
module sim_irq_pin_servicer;
  localparam int N = 4, VW = 8, DW = 8, MW = 3, LIM = 3, DEF = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rstN = 1'b0;
  logic [N-1:0]   pinLevel = '0, cfgDestMode, cfgLevelTrig = '0, cfgMask = '0;
  logic [N*VW-1:0] cfgVector;
  logic [N*DW-1:0] cfgDest;
  logic [N*MW-1:0] cfgDelivMode;
  logic           eoiValid = 1'b0, directedEoi = 1'b0, msgReady = 1'b0;
  logic [VW-1:0]  eoiVector = '0;
  logic           msgValid, msgDestMode, msgLevelTrig;
  logic [VW-1:0]  msgVector;
  logic [DW-1:0]  msgDest;
  logic [MW-1:0]  msgDelivMode;
  logic [5:0]     msgPin;
  logic [N-1:0]   irr, remoteIrr, coalesced;

  irq_pin_servicer #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW), .MODE_W(MW),
    .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) u0 (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .cfgVector(cfgVector),
    .cfgDest(cfgDest), .cfgDestMode(cfgDestMode), .cfgDelivMode(cfgDelivMode),
    .cfgLevelTrig(cfgLevelTrig), .cfgMask(cfgMask), .eoiValid(eoiValid),
    .eoiVector(eoiVector), .directedEoi(directedEoi), .msgReady(msgReady),
    .msgValid(msgValid), .msgVector(msgVector), .msgDest(msgDest),
    .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode),
    .msgLevelTrig(msgLevelTrig), .msgPin(msgPin), .irr(irr),
    .remoteIrr(remoteIrr), .coalesced(coalesced));

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic acceptMsg();
    msgReady = 1'b1;
    step();
    msgReady = 1'b0;
  endtask

  task automatic waitMsg(output int n);
    n = 0;
    while (!msgValid && n < 100) begin
      step();
      n++;
    end
  endtask

  task automatic eoiPulse(input logic [7:0] v, input logic dir);
    eoiVector   = v;
    directedEoi = dir;
    eoiValid    = 1'b1;
    step();
    eoiValid    = 1'b0;
    directedEoi = 1'b0;
  endtask

  task automatic eoiCount(input logic [7:0] v, output int n);
    eoiPulse(v, 1'b0);
    n = 1;
    while (!msgValid && n < 100) begin
      step();
      n++;
    end
  endtask

  function automatic logic [7:0] vecOf(input int i);
    return 8'h20 + 8'(i);
  endfunction
  function automatic logic [7:0] destOf(input int i);
    return 8'h10 + 8'(3 * i);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < N; i++) begin
      cfgVector[i*VW +: VW]    = vecOf(i);
      cfgDest[i*DW +: DW]      = destOf(i);
      cfgDelivMode[i*MW +: MW] = MW'(i);
      cfgDestMode[i]           = i[0];
    end
    repeat (3) step();
    chk("R1 irr", 32'(irr), 0);
    chk("R1 remoteIrr", 32'(remoteIrr), 0);
    chk("R1 msgValid", 32'(msgValid), 0);
    chk("R1 coalesced", 32'(coalesced), 0);
    rstN = 1'b1;
    step();

    // Edge sweep over every pin: delivery, fields, latching, coalescing, accept.
    for (int i = 0; i < N; i++) begin
      pinLevel[i] = 1'b1;
      step();
      chk("R2 edge sets irr", 32'(irr), 32'(1 << i));
      chk("R6 not yet valid", 32'(msgValid), 0);
      step();
      chk("R6 valid", 32'(msgValid), 1);
      chk("R6 pin", 32'(msgPin), 32'(i));
      chk("R6 vector", 32'(msgVector), 32'(vecOf(i)));
      chk("R6 dest", 32'(msgDest), 32'(destOf(i)));
      chk("R6 destMode", 32'(msgDestMode), 32'(i % 2));
      chk("R6 delivMode", 32'(msgDelivMode), 32'(i));
      chk("R6 levelTrig", 32'(msgLevelTrig), 0);
      pinLevel[i] = 1'b0;
      step();
      chk("R2 edge irr kept", 32'(irr[i]), 1);
      chk("R6 stable", 32'(msgVector), 32'(vecOf(i)));
      pinLevel[i] = 1'b1;
      step();
      chk("R3 coalesced flag", 32'(coalesced), 32'(1 << i));
      step();
      chk("R3 flag one cycle", 32'(coalesced), 0);
      acceptMsg();
      chk("R7 edge irr cleared", 32'(irr[i]), 0);
      step();
      chk("R3 no extra message", 32'(msgValid), 0);
      pinLevel[i] = 1'b0;
      step();
    end

    // All pins at once: lowest index first.
    pinLevel = '1;
    for (int k = 0; k < N; k++) begin
      waitMsg(n);
      chk("R6 priority order", 32'(msgPin), 32'(k));
      acceptMsg();
    end
    pinLevel = '0;
    step();

    // Mask holds the request, unmask releases it.
    cfgMask[2] = 1'b1;
    pinLevel[2] = 1'b1;
    repeat (4) step();
    chk("R5 masked no message", 32'(msgValid), 0);
    chk("R5 masked irr kept", 32'(irr[2]), 1);
    cfgMask[2] = 1'b0;
    step();
    chk("R5 unmask delivers", 32'(msgValid), 1);
    chk("R5 unmask pin", 32'(msgPin), 2);
    acceptMsg();
    pinLevel[2] = 1'b0;
    step();

    // Level pin 1, vector 0x40.
    cfgLevelTrig[1] = 1'b1;
    cfgVector[1*VW +: VW] = 8'h40;
    pinLevel[1] = 1'b1;
    waitMsg(n);
    chk("R6 level msg", 32'(msgLevelTrig), 1);
    acceptMsg();
    chk("R7 remote set", 32'(remoteIrr), 32'b0010);
    repeat (3) step();
    chk("R4 held no message", 32'(msgValid), 0);
    chk("R4 irr held", 32'(irr[1]), 1);
    pinLevel[1] = 1'b0;
    step();
    chk("R2 level fall clears", 32'(irr[1]), 0);
    eoiPulse(8'h40, 1'b0);
    chk("R8 eoi clears remote", 32'(remoteIrr), 0);
    step();
    chk("R2 level low no delivery", 32'(msgValid), 0);

    // Shared vector 0x40 on level pins 1, 3 and edge pin 0.
    cfgLevelTrig[3] = 1'b1;
    cfgVector[3*VW +: VW] = 8'h40;
    cfgVector[0*VW +: VW] = 8'h40;
    pinLevel[1] = 1'b1;
    pinLevel[3] = 1'b1;
    waitMsg(n);
    chk("R6 pin1 first", 32'(msgPin), 1);
    acceptMsg();
    waitMsg(n);
    chk("R6 pin3 next", 32'(msgPin), 3);
    acceptMsg();
    chk("R7 both in service", 32'(remoteIrr), 32'b1010);
    pinLevel[0] = 1'b1;
    waitMsg(n);
    acceptMsg();
    pinLevel[0] = 1'b0;
    eoiPulse(8'h40, 1'b1);
    chk("R8 directed no clear", 32'(remoteIrr), 32'b1010);
    eoiPulse(8'h41, 1'b0);
    chk("R8 other vector no clear", 32'(remoteIrr), 32'b1010);
    eoiPulse(8'h40, 1'b0);
    chk("R8 shared clear", 32'(remoteIrr), 0);
    step();
    chk("R9 redeliver pin1", 32'(msgPin), 1);
    chk("R9 redeliver valid", 32'(msgValid), 1);
    acceptMsg();
    waitMsg(n);
    chk("R9 redeliver pin3", 32'(msgPin), 3);
    acceptMsg();
    pinLevel[1] = 1'b0;
    pinLevel[3] = 1'b0;
    step();
    eoiPulse(8'h40, 1'b0);
    cfgLevelTrig[3] = 1'b0;
    cfgVector[3*VW +: VW] = vecOf(3);
    cfgVector[0*VW +: VW] = vecOf(0);
    step();

    // Storm throttling on pin 1.
    pinLevel[1] = 1'b1;
    waitMsg(n);
    acceptMsg();
    for (int j = 1; j <= LIM; j++) begin
      eoiCount(8'h40, n);
      chk(j < LIM ? "R9 immediate repeat" : "R10 deferred repeat",
          32'(n), j < LIM ? 32'd2 : 32'(DEF + 2));
      acceptMsg();
    end
    eoiCount(8'h40, n);
    chk("R10 counter restarted", 32'(n), 2);
    acceptMsg();
    eoiCount(8'h40, n);
    chk("R9 second repeat", 32'(n), 2);
    acceptMsg();
    pinLevel[1] = 1'b0;
    step();
    eoiPulse(8'h40, 1'b0);
    pinLevel[1] = 1'b1;
    waitMsg(n);
    acceptMsg();
    eoiCount(8'h40, n);
    chk("R9 count reset first", 32'(n), 2);
    acceptMsg();
    eoiCount(8'h40, n);
    chk("R9 count reset second", 32'(n), 2);
    acceptMsg();
    eoiCount(8'h40, n);
    chk("R9 count reset storm", 32'(n), 32'(DEF + 2));
    acceptMsg();

    // Reset cancels a deferral in progress.
    for (int j = 1; j < LIM; j++) begin
      eoiCount(8'h40, n);
      acceptMsg();
    end
    eoiPulse(8'h40, 1'b0);
    repeat (5) step();
    chk("R10 still deferred", 32'(msgValid), 0);
    rstN = 1'b0;
    step();
    step();
    rstN = 1'b1;
    chk("R11 irr cleared", 32'(irr), 0);
    chk("R11 remote cleared", 32'(remoteIrr), 0);
    chk("R11 msgValid cleared", 32'(msgValid), 0);
    waitMsg(n);
    chk("R11 no leftover hold", 32'(n), 2);
    acceptMsg();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule